// File: doc/BRIEF.md
# Serial Video Descrambler and Word Framer

This block receives a bit-serial digital video stream, one bit per cycle in which the serial enable is high, and turns it into 10-bit parallel words. Each accepted bit is first NRZI-decoded and then passed through a self-synchronising descrambler built on x^9+x^4+1. The descrambled bits fill a 30-bit window. Whenever the three most recent words in that window form a timing reference (3FF, then 000, then 000), the block reports a sync hit and the bit phase at which the hit occurred.

A free-running word timer divides the accepted bits by ten. It drives a one-cycle word strobe, the parallel data and a parallel clock that is high for half a word. An external alignment controller watches the sync hit and decides through a permit input whether an off-phase reference may move the word boundary. A reference that falls on a word boundary, or that is permitted to move it, toggles an HSYNC line one word ahead of the 3FF word on the parallel output.

The serial input has no ready signal. The line cannot be stalled, so a bit is taken whenever the enable is high. The parallel side is a strobe without back-pressure: each word is valid only in its one strobe cycle, and the receiver must take it then.

Top module: `svf_deserializer`

## Requirements
- R1: The descrambler state resets to zero. Each accepted bit r gives d = r XOR previous r, and output = d XOR d(4 bits earlier) XOR d(9 bits earlier). Bits of a word arrive LSB first and land on par_data[0] up to par_data[9], with bit 9 the MSB. An 8-bit source occupies par_data[9:2].
- R2: sync_hit is high for one cycle. It occurs in the cycle after the cycle that presents the bit completing 3FF, 000, 000, where 3FF is the oldest of the three words. In that cycle sync_offset gives the timer phase (0 to 9) of that bit. The value 9 means the reference already sits on a word boundary.
- R3: From reset, every tenth accepted bit ends a word. par_valid is high for exactly one cycle, two cycles after the cycle that presents that bit, so consecutive strobes are ten cycles apart when the input is continuous.
- R4: A sync hit with sync_offset not equal to 9 and align_permit high makes the hit bit a word boundary. Later boundaries follow every ten bits from it, and the words that follow are contiguous.
- R5: A sync hit with sync_offset not equal to 9 and align_permit low changes neither the word timing nor hsync.
- R6: hsync inverts once for each reference that is on a boundary (whatever align_permit is) or is permitted to realign. The inversion happens in the same cycle as a par_valid strobe. The next three strobes carry 3FF, 000 and 000, and the data that follows comes out in order.
- R7: par_clk falls in the cycle of each regular word strobe. It rises after the fifth bit of the word, so with continuous input it is high for 5 cycles and low for 5.
- R8: Cycles with ser_valid low are ignored: ser_data is not taken, and no state advances.
- R9: During reset, par_valid, par_data, par_clk, hsync and sync_hit are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_valid | input | 1 | Serial enable; one bit is taken per high cycle |
| ser_data | input | 1 | Scrambled, NRZI-coded serial bit |
| align_permit | input | 1 | Allows an off-phase sync hit to move the word boundary |
| par_valid | output | 1 | One-cycle strobe per parallel word |
| par_data | output | 10 | Descrambled parallel word, bit 9 MSB |
| par_clk | output | 1 | Parallel clock, rising mid-word |
| hsync | output | 1 | Toggles once per accepted timing reference |
| sync_hit | output | 1 | Reference seen in the window this cycle |
| sync_offset | output | 4 | Timer phase of the bit completing the reference |

## Verification
A bit presented in cycle c is shifted into the window at the end of c. That bit's sync hit is visible in c+1, and any strobe or hsync inversion it causes is visible in c+2. The bench logs the time of every bit it drives and every strobe it observes, and checks the toggle strobe at exactly two clock periods after the last reference bit. Word contents are checked by their index after the toggle strobe: +1 gives 3FF, +2 and +3 give 000, and the data follows from +4. Strobe spacing and par_clk high time are checked against ten and five cycles in the continuous segments. The segment with gaps in the enable is checked on content only.

// File: rtl/svf_pkg.sv
`timescale 1ns/1ps
package svf_pkg;

  // Classification of a sync hit against the running word timer.
  typedef enum logic [1:0] {
    HIT_NONE    = 2'd0,
    HIT_ON_SLOT = 2'd1,
    HIT_MOVE    = 2'd2,
    HIT_BLOCKED = 2'd3
  } svf_hit_e;

  // Reference pattern: the oldest word in the window is all ones,
  // every younger word is all zeros.
  function automatic logic ref_bit(input int word_idx);
    return (word_idx == 0);
  endfunction

endpackage

// File: rtl/svf_descrambler.sv
`timescale 1ns/1ps
module svf_descrambler #(
  parameter int unsigned TAP_NEAR = 4,
  parameter int unsigned TAP_FAR  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_in,
  output logic plain_bit
);

  logic                line_q;
  logic [TAP_FAR-1:0]  hist_q;
  logic                nrzi_bit;

  // NRZI decode: a transition on the line means a one.
  assign nrzi_bit  = bit_in ^ line_q;
  // Self-synchronising descramble over the decoded history (R1).
  assign plain_bit = nrzi_bit ^ hist_q[TAP_NEAR-1] ^ hist_q[TAP_FAR-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      hist_q <= '0;
    end else if (bit_valid) begin
      line_q <= bit_in;
      hist_q <= {hist_q[TAP_FAR-2:0], nrzi_bit};
    end
  end

  // R8: idle cycles leave the descrambler history untouched
  a_r8_idle_keeps_history: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(hist_q) && $stable(line_q)));

endmodule

// File: rtl/svf_sync_window.sv
`timescale 1ns/1ps
module svf_sync_window #(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned NUM_WORDS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic              fresh,
  output logic              hit,
  output logic [WORD_W-1:0] oldest
);

  localparam int unsigned WIN_W = WORD_W * NUM_WORDS;

  logic [WIN_W-1:0]     win_q;
  logic                 fresh_q;
  logic [NUM_WORDS-1:0] word_ok;

  // LSB-first stream: the new bit enters at the top, the oldest word
  // sits in the low slice.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= shift_en;
      if (shift_en) begin
        win_q <= {din, win_q[WIN_W-1:1]};
      end
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word_cmp
    localparam logic REF = svf_pkg::ref_bit(g);
    assign word_ok[g] = (win_q[g*WORD_W +: WORD_W] == {WORD_W{REF}});
  end

  assign fresh  = fresh_q;
  assign hit    = fresh_q & (&word_ok);
  assign oldest = win_q[WORD_W-1:0];

endmodule

// File: rtl/svf_word_timer.sv
`timescale 1ns/1ps
module svf_word_timer #(
  parameter int unsigned WORD_W = 10,
  localparam int unsigned PH_W  = $clog2(WORD_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            realign,
  output logic            boundary,
  output logic [PH_W-1:0] phase,
  output logic            pclk
);

  localparam logic [PH_W-1:0] LAST    = PH_W'(WORD_W - 1);
  localparam logic [PH_W-1:0] RISE_AT = PH_W'(WORD_W / 2 - 1);

  logic [PH_W-1:0] phase_q;
  logic            pclk_q;

  assign boundary = step && ((phase_q == LAST) || realign);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      pclk_q  <= 1'b0;
    end else if (boundary) begin
      phase_q <= '0;
      pclk_q  <= 1'b0;
    end else if (step) begin
      phase_q <= phase_q + PH_W'(1);
      if (phase_q == RISE_AT) pclk_q <= 1'b1;
    end
  end

  assign phase = phase_q;
  assign pclk  = pclk_q;

  // R3: the phase never leaves its word range
  a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);

  // R3/R5: an ordinary bit moves the phase by exactly one
  a_r5_plain_step_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !realign && (phase_q != LAST)) |=> (phase_q == $past(phase_q) + PH_W'(1)));

  // R4: a realignment restarts the word count
  a_r4_realign_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (step && realign) |=> (phase_q == '0));

  // R7: the parallel clock is low straight after a boundary
  a_r7_low_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> !pclk_q);

endmodule

// File: rtl/svf_deserializer.sv
`timescale 1ns/1ps
module svf_deserializer #(
  parameter int unsigned WORD_W   = 10,
  parameter int unsigned TAP_NEAR = 4,
  parameter int unsigned TAP_FAR  = 9,
  localparam int unsigned PH_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_valid,
  input  logic              ser_data,
  input  logic              align_permit,
  output logic              par_valid,
  output logic [WORD_W-1:0] par_data,
  output logic              par_clk,
  output logic              hsync,
  output logic              sync_hit,
  output logic [PH_W-1:0]   sync_offset
);

  import svf_pkg::*;

  localparam logic [PH_W-1:0] LAST = PH_W'(WORD_W - 1);

  logic              plain_bit;
  logic              fresh;
  logic              hit;
  logic [WORD_W-1:0] oldest;
  logic              boundary;
  logic [PH_W-1:0]   phase;
  logic              pclk_int;
  svf_hit_e          kind;
  logic              realign;
  logic              take_ref;

  logic              valid_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] data_q;
  logic              hsync_q;

  svf_descrambler #(
    .TAP_NEAR (TAP_NEAR),
    .TAP_FAR  (TAP_FAR)
  ) u_descr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (ser_valid),
    .bit_in    (ser_data),
    .plain_bit (plain_bit)
  );

  svf_sync_window #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (3)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (ser_valid),
    .din      (plain_bit),
    .fresh    (fresh),
    .hit      (hit),
    .oldest   (oldest)
  );

  // Judge a hit against the current word timing.
  always_comb begin
    if (!hit)                kind = HIT_NONE;
    else if (phase == LAST)  kind = HIT_ON_SLOT;
    else if (align_permit)   kind = HIT_MOVE;
    else                     kind = HIT_BLOCKED;
  end

  assign realign  = (kind == HIT_MOVE);
  assign take_ref = (kind == HIT_ON_SLOT) || (kind == HIT_MOVE);

  svf_word_timer #(
    .WORD_W (WORD_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (fresh),
    .realign  (realign),
    .boundary (boundary),
    .phase    (phase),
    .pclk     (pclk_int)
  );

  // One word of holding delay puts the hsync edge a word ahead of 3FF.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hold_q  <= '0;
      data_q  <= '0;
      hsync_q <= 1'b0;
    end else begin
      valid_q <= boundary;
      if (boundary) begin
        hold_q <= oldest;
        data_q <= hold_q;
      end
      if (take_ref) hsync_q <= ~hsync_q;
    end
  end

  assign par_valid   = valid_q;
  assign par_data    = data_q;
  assign par_clk     = pclk_int;
  assign hsync       = hsync_q;
  assign sync_hit    = hit;
  assign sync_offset = phase;

  // R6: hsync only moves together with a word strobe
  a_r6_hsync_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hsync_q) |-> valid_q);

  // R7: every fall of the parallel clock coincides with a strobe
  a_r7_pclk_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_int) |-> valid_q);

  // R5: a blocked off-phase hit leaves hsync alone
  a_r5_blocked_keeps_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !align_permit && (phase != LAST)) |=> $stable(hsync_q));

  // R2: hits are isolated one-cycle pulses
  a_r2_hit_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: tb/svf_deserializer_bench.sv
`timescale 1ns/1ps
module svf_deserializer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_valid;
  logic       ser_data;
  logic       align_permit;
  logic       par_valid;
  logic [9:0] par_data;
  logic       par_clk;
  logic       hsync;
  logic       sync_hit;
  logic [3:0] sync_offset;

  always #10 clk = ~clk;

  svf_deserializer u_svf_deserializer (
    .clk          (clk),
    .rst_n        (rst_n),
    .ser_valid    (ser_valid),
    .ser_data     (ser_data),
    .align_permit (align_permit),
    .par_valid    (par_valid),
    .par_data     (par_data),
    .par_clk      (par_clk),
    .hsync        (hsync),
    .sync_hit     (sync_hit),
    .sync_offset  (sync_offset)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // transmitter model (scramble then NRZI encode)
  logic [8:0] tx_h    = '0;
  logic       tx_line = 1'b0;
  bit         gap_mode = 1'b0;
  longint     last_bit_t = 0;

  // monitor log
  int     cap_w  [256];
  longint cap_tm [256];
  int     cap_p  [256];
  bit     cap_t  [256];
  int     ncap = 0;
  int     hi_run = 0;
  logic   hs_seen = 1'b0;
  int     stray = 0;
  int     hit_n = 0;
  int     last_off = -1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dw(input int k);
    return 'h040 + ((k * 37) % 768);
  endfunction

  function automatic int d8(input int k);
    return (((k * 29) % 255) + 1) << 2;
  endfunction

  task automatic send_bit(input logic x);
    logic d;
    d       = x ^ tx_h[3] ^ tx_h[8];
    tx_h    = {tx_h[7:0], d};
    tx_line = tx_line ^ d;
    @(negedge clk);
    ser_data   = tx_line;
    ser_valid  = 1'b1;
    last_bit_t = $time;
    if (gap_mode) begin
      @(negedge clk);
      ser_valid = 1'b0;
      ser_data  = ~tx_line;
    end
  endtask

  task automatic send_word(input int w);
    for (int i = 0; i < 10; i++) send_bit(w[i]);
  endtask

  task automatic send_ref();
    send_word('h3FF);
    send_word(0);
    send_word(0);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    ser_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int find_toggle(input int from);
    for (int i = from; i < ncap; i++) if (cap_t[i]) return i;
    return -1;
  endfunction

  function automatic int count_toggles(input int from);
    int c = 0;
    for (int i = from; i < ncap; i++) if (cap_t[i]) c++;
    return c;
  endfunction

  // monitor samples on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (par_valid) begin
        if (ncap < 255) begin
          cap_w[ncap]  = int'(par_data);
          cap_tm[ncap] = $time;
          cap_p[ncap]  = hi_run;
          cap_t[ncap]  = (hsync != hs_seen);
          ncap++;
        end
        hs_seen = hsync;
        hi_run  = 0;
      end else if (hsync != hs_seen) begin
        stray++;
        hs_seen = hsync;
      end
      if (par_clk) hi_run++;
      if (sync_hit) begin
        hit_n++;
        last_off = int'(sync_offset);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int m, t, hb;
    longint ref_end;
    rst_n = 1'b0; ser_valid = 1'b0; ser_data = 1'b0; align_permit = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(par_valid == 1'b0, "R9 par_valid in reset", int'(par_valid), 0);
    chk(par_data == '0,    "R9 par_data in reset",  int'(par_data), 0);
    chk(par_clk == 1'b0,   "R9 par_clk in reset",   int'(par_clk), 0);
    chk(hsync == 1'b0,     "R9 hsync in reset",     int'(hsync), 0);
    chk(sync_hit == 1'b0,  "R9 sync_hit in reset",  int'(sync_hit), 0);
    rst_n = 1'b1;

    // Segment B: off-phase reference, permitted -> realign (R2 R3 R4 R6 R7 R1)
    align_permit = 1'b1;
    m = ncap;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    for (int k = 0; k < 8; k++) send_word(dw(k));
    send_ref();
    ref_end = last_bit_t;
    for (int k = 8; k < 31; k++) send_word(dw(k));
    idle(30);
    chk(hit_n == 1, "R2 one hit in first segment", hit_n, 1);
    chk(last_off == 2, "R2 offset of first hit", last_off, 2);
    t = find_toggle(m);
    chk(t >= 0, "R6 toggle seen after permitted hit", t, 0);
    chk(count_toggles(m) == 1, "R6 single toggle per reference", count_toggles(m), 1);
    if (t >= 0) begin
      chk(cap_tm[t] == ref_end + 40, "R3 toggle strobe two cycles after last bit",
          int'(cap_tm[t] - ref_end), 40);
      chk(cap_w[t+1] == 'h3FF, "R6 first word after toggle", cap_w[t+1], 'h3FF);
      chk(cap_w[t+2] == 0, "R6 second reference word", cap_w[t+2], 0);
      chk(cap_w[t+3] == 0, "R6 third reference word", cap_w[t+3], 0);
      for (int j = 0; j < 20; j++)
        chk(cap_w[t+4+j] == dw(8+j), "R4 R1 contiguous data after realign",
            cap_w[t+4+j], dw(8+j));
      for (int j = 1; j < 23; j++) begin
        chk(cap_tm[t+j] - cap_tm[t+j-1] == 200, "R3 strobe spacing ten cycles",
            int'(cap_tm[t+j] - cap_tm[t+j-1]), 200);
        chk(cap_p[t+j] == 5, "R7 par_clk high five cycles", cap_p[t+j], 5);
      end
    end

    // Segment C: off-phase reference with permit low (R5 R2)
    align_permit = 1'b0;
    hb = hit_n;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    m = ncap;
    for (int k = 40; k < 46; k++) send_word(dw(k));
    send_ref();
    for (int k = 46; k < 52; k++) send_word(dw(k));
    idle(30);
    chk(hit_n == hb + 1, "R5 blocked reference still reported", hit_n, hb + 1);
    chk(last_off == 3, "R2 offset of blocked hit", last_off, 3);
    chk(count_toggles(m) == 0, "R5 no hsync toggle when blocked", count_toggles(m), 0);
    for (int j = m + 1; j < ncap - 1; j++)
      chk(cap_tm[j] - cap_tm[j-1] == 200, "R5 word timing unchanged when blocked",
          int'(cap_tm[j] - cap_tm[j-1]), 200);

    // Segment D: same offset, permitted, enable with gaps (R4 R8)
    align_permit = 1'b1;
    gap_mode = 1'b1;
    m = ncap;
    send_ref();
    for (int k = 60; k < 75; k++) send_word(dw(k));
    gap_mode = 1'b0;
    idle(60);
    chk(last_off == 3, "R4 offset of permitted hit", last_off, 3);
    t = find_toggle(m);
    chk(t >= 0, "R4 toggle after permitted realign", t, 0);
    if (t >= 0) begin
      chk(cap_w[t+1] == 'h3FF, "R8 reference word with gaps", cap_w[t+1], 'h3FF);
      for (int j = 0; j < 12; j++)
        chk(cap_w[t+4+j] == dw(60+j), "R8 data unaffected by idle cycles",
            cap_w[t+4+j], dw(60+j));
    end

    // Segment E: on-phase reference with permit low, 8-bit data (R6 R1 R3)
    align_permit = 1'b0;
    m = ncap;
    send_ref();
    ref_end = last_bit_t;
    for (int k = 0; k < 9; k++) send_word(d8(k));
    idle(30);
    chk(last_off == 9, "R2 on-phase offset", last_off, 9);
    t = find_toggle(m);
    chk(t >= 0, "R6 on-phase reference toggles without permit", t, 0);
    if (t >= 0) begin
      chk(cap_tm[t] == ref_end + 40, "R3 on-phase toggle timing",
          int'(cap_tm[t] - ref_end), 40);
      chk(cap_w[t+1] == 'h3FF, "R6 3FF follows on-phase toggle", cap_w[t+1], 'h3FF);
      for (int j = 0; j < 6; j++)
        chk(cap_w[t+4+j] == d8(j), "R1 8-bit source in upper bits",
            cap_w[t+4+j], d8(j));
    end
    chk(stray == 0, "R6 hsync never moves outside a strobe", stray, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule